// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target has left holding SDA low. When asked, it takes over the SCL and SDA pins and drives them as plain open-drain outputs. It first releases both lines and then forms a START. Next it clocks a fixed number of SCL pulses with SDA released, which lets a target that is stuck part-way through a byte finish shifting and release the bus. It ends with SDA low, then SCL released, then SDA released, which is a STOP. After that it returns the pins to the normal I2C controller. In the same cycle it pulses a reset that aborts the controller's current transaction and clears its status.

Every line change is followed by a dwell of `DWELL_TICKS` counts of the `tick_i` enable. With `tick_i` tied high, each dwell is that many clock cycles. Once the last dwell has expired, the sequencer samples the two line levels. The result is held on `idle_ok_o`, and the surrounding logic must reject the pending transfer when this flag is low. The block has no data stream, so it has no valid/ready interface. `go_i` is a level sampled only while the block is idle, and all outputs are plain levels or single-cycle pulses.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, `pin_own_o`, `scl_oe_o`, `sda_oe_o`, `done_o`, `ctrl_rst_o` and `idle_ok_o` are all 0.
- R2: A high `go_i` at a clock edge while the block is idle starts a sequence. From the next cycle `pin_own_o` is 1 and both lines are released (`scl_oe_o`=0, `sda_oe_o`=0) for the first dwell.
- R3: Each step lasts exactly `DWELL_TICKS` cycles in which `tick_i` is high. Cycles with `tick_i` low leave the step and the line drives unchanged. With `tick_i` always high, `pin_own_o` stays high for 24·`DWELL_TICKS` cycles when `NUM_PULSES`=9.
- R4: The START is two steps. First `sda_oe_o`=1 with `scl_oe_o`=0, then both enables are 1.
- R5: Exactly `NUM_PULSES` clock pulses follow. Each is one step with both enables 0 (SCL high, SDA released) and then one step with `scl_oe_o`=1 and `sda_oe_o`=0. Across the whole sequence, `scl_oe_o` falls from 1 to 0 exactly `NUM_PULSES`+1 times.
- R6: The pulses are followed by three steps: both enables 1 (SDA low), then `sda_oe_o`=1 with `scl_oe_o`=0, then both enables 0 (STOP).
- R7: In the cycle after the final dwell expires, `done_o` and `ctrl_rst_o` are 1 for exactly one cycle and `pin_own_o` is 0. The block is then idle.
- R8: `idle_ok_o` takes `scl_in_i & sda_in_i` as sampled at the edge where the final dwell expires. It holds that value until the next accepted `go_i`, which clears it to 0.
- R9: `go_i` has no effect while a sequence runs or in the `done_o` cycle. The running sequence keeps its length and order.
- R10: While `pin_own_o` is 0, both `scl_oe_o` and `sda_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start request, sampled while idle |
| tick_i | input | 1 | Dwell counting enable |
| scl_in_i | input | 1 | Sampled SCL level |
| sda_in_i | input | 1 | Sampled SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| pin_own_o | output | 1 | Sequencer owns the pins |
| ctrl_rst_o | output | 1 | One-cycle reset to the I2C controller |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| idle_ok_o | output | 1 | Both lines were high after recovery |

## Verification
The bench targets the tick count at each step boundary. A dwell that ends one tick early or late shifts every later edge, and the per-cycle comparison catches it at the first step that moves. It also pulses `go_i` during a run and holds it high across the `done_o` cycle. A block that restarted mid-sequence or repeated the end pulse would show a wrong `pin_own_o` or a second `done_o`. It counts SCL releases to catch a pulse counter that stops after eight or ten pulses. Finally, it holds SCL low externally so that `idle_ok_o` must come out 0, which exposes a flag sampled too early or never cleared.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_START_SDA,
    ST_START_SCL,
    ST_PULSE_HI,
    ST_PULSE_LO,
    ST_DATA_LO,
    ST_STOP_SCL,
    ST_STOP_SDA,
    ST_FINISH
  } step_e;
endpackage

// File: rtl/unstick_dwell.sv
module unstick_dwell #(
  parameter int DWELL_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(DWELL_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DWELL_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import unstick_pkg::*;
#(
  parameter int NUM_PULSES = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_i,
  input  logic  expire_i,
  input  logic  line_ok_i,
  output step_e step_o,
  output logic  run_o,
  output logic  idle_ok_o
);
  localparam int PW = $clog2(NUM_PULSES + 1);
  localparam logic [PW-1:0] PLAST = PW'(NUM_PULSES - 1);

  step_e         step_q, step_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          ok_q;

  always_comb begin
    step_d = step_q;
    pcnt_d = pcnt_q;
    unique case (step_q)
      ST_IDLE: if (go_i) begin
        step_d = ST_PRE;
        pcnt_d = '0;
      end
      ST_FINISH: step_d = ST_IDLE;
      default: if (expire_i) begin
        unique case (step_q)
          ST_PRE:       step_d = ST_START_SDA;
          ST_START_SDA: step_d = ST_START_SCL;
          ST_START_SCL: step_d = ST_PULSE_HI;
          ST_PULSE_HI:  step_d = ST_PULSE_LO;
          ST_PULSE_LO:
            if (pcnt_q == PLAST) step_d = ST_DATA_LO;
            else begin
              step_d = ST_PULSE_HI;
              pcnt_d = pcnt_q + 1'b1;
            end
          ST_DATA_LO:   step_d = ST_STOP_SCL;
          ST_STOP_SCL:  step_d = ST_STOP_SDA;
          ST_STOP_SDA:  step_d = ST_FINISH;
          default:      step_d = ST_IDLE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      pcnt_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      pcnt_q <= pcnt_d;
      if (step_q == ST_IDLE && go_i) ok_q <= 1'b0;
      else if (step_q == ST_STOP_SDA && expire_i) ok_q <= line_ok_i;
    end
  end

  assign step_o    = step_q;
  assign run_o     = (step_q != ST_IDLE) && (step_q != ST_FINISH);
  assign idle_ok_o = ok_q;

  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < PW'(NUM_PULSES));

  p_finish_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_FINISH) |=> (step_q == ST_IDLE));

  p_ok_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ok_q) |-> ($past(step_q) == ST_STOP_SDA || $past(step_q) == ST_IDLE));

  p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && step_q != ST_PRE && !expire_i) |=> $stable(step_q));
endmodule

// File: rtl/unstick_lines.sv
module unstick_lines
  import unstick_pkg::*;
(
  input  step_e step_i,
  output logic  scl_low_o,
  output logic  sda_low_o,
  output logic  own_o,
  output logic  finish_o
);
  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    own_o     = 1'b1;
    finish_o  = 1'b0;
    unique case (step_i)
      ST_IDLE:      own_o = 1'b0;
      ST_FINISH: begin
        own_o    = 1'b0;
        finish_o = 1'b1;
      end
      ST_PRE, ST_PULSE_HI, ST_STOP_SDA: ;
      ST_START_SDA, ST_STOP_SCL: sda_low_o = 1'b1;
      ST_START_SCL, ST_DATA_LO: begin
        scl_low_o = 1'b1;
        sda_low_o = 1'b1;
      end
      ST_PULSE_LO:  scl_low_o = 1'b1;
      default:      own_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
  import unstick_pkg::*;
#(
  parameter int DWELL_TICKS = 1000,
  parameter int NUM_PULSES  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic tick_i,
  input  logic scl_in_i,
  input  logic sda_in_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic pin_own_o,
  output logic ctrl_rst_o,
  output logic done_o,
  output logic idle_ok_o
);
  step_e step;
  logic  run, expire, finish;

  unstick_dwell #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i), .expire_o(expire)
  );

  unstick_fsm #(.NUM_PULSES(NUM_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .expire_i(expire),
    .line_ok_i(scl_in_i & sda_in_i), .step_o(step), .run_o(run),
    .idle_ok_o(idle_ok_o)
  );

  unstick_lines u_lines (
    .step_i(step), .scl_low_o(scl_oe_o), .sda_low_o(sda_oe_o),
    .own_o(pin_own_o), .finish_o(finish)
  );

  assign done_o     = finish;
  assign ctrl_rst_o = finish;

  p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_own_o |-> (!scl_oe_o && !sda_oe_o));

  p_own_drop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_own_o) |-> done_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_sda_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_own_o) |=> (!scl_oe_o && !sda_oe_o) || (!scl_oe_o && sda_oe_o));
endmodule

// File: tb/i2c_unstick_seq_bench.sv
module i2c_unstick_seq_bench;
  localparam int D  = 3;
  localparam int NP = 9;
  localparam int NSTEP = 6 + 2 * NP;

  logic clk = 1'b0;
  logic rst_n, go, tick, scl_hold, sda_hold;
  logic scl_oe, sda_oe, own, crst, done, ok;
  wire  scl_in = !scl_oe && !scl_hold;
  wire  sda_in = !sda_oe && !sda_hold;

  int total = 0, bad = 0, cyc = 0, tick_mode = 0;
  int m_step = -1, m_cnt = 0;
  bit m_ok = 0;

  always #2.5 clk = ~clk;

  i2c_unstick_seq #(.DWELL_TICKS(D), .NUM_PULSES(NP)) u_i2c_unstick_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .tick_i(tick),
    .scl_in_i(scl_in), .sda_in_i(sda_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .pin_own_o(own), .ctrl_rst_o(crst), .done_o(done), .idle_ok_o(ok)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void exp_lines(int s, output int sl, output int dl);
    sl = 0; dl = 0;
    if (s == 1) dl = 1;
    else if (s == 2) begin sl = 1; dl = 1; end
    else if (s >= 3 && s < 3 + 2 * NP) sl = ((s - 3) % 2 == 1) ? 1 : 0;
    else if (s == 3 + 2 * NP) begin sl = 1; dl = 1; end
    else if (s == 4 + 2 * NP) dl = 1;
  endfunction

  function automatic string tag_of(int s);
    if (s < 0 || s == NSTEP) return "R10";
    if (s == 0) return "R2";
    if (s <= 2) return "R4";
    if (s < 3 + 2 * NP) return "R5";
    return "R6";
  endfunction

  // reference model
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_step = -1; m_cnt = 0; m_ok = 0;
    end else if (m_step == -1) begin
      if (go) begin m_step = 0; m_cnt = 0; m_ok = 0; end
    end else if (m_step == NSTEP) begin
      m_step = -1;
    end else if (tick) begin
      if (m_cnt == D - 1) begin
        m_cnt = 0;
        if (m_step == NSTEP - 1) m_ok = scl_in && sda_in;
        m_step++;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    int sl, dl;
    if (rst_n) begin
      exp_lines(m_step, sl, dl);
      chk({tag_of(m_step), " scl_oe (R3 timing)"}, int'(scl_oe), sl);
      chk({tag_of(m_step), " sda_oe (R3 timing)"}, int'(sda_oe), dl);
      chk("R2 own", int'(own), (m_step >= 0 && m_step < NSTEP) ? 1 : 0);
      chk("R7 done", int'(done), (m_step == NSTEP) ? 1 : 0);
      chk("R7 ctrl_rst", int'(crst), (m_step == NSTEP) ? 1 : 0);
      chk("R8 idle_ok", int'(ok), int'(m_ok));
    end
    case (tick_mode)
      0: tick = 1'b1;
      1: tick = (cyc % 3 == 0);
      default: tick = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_one(bit poke, output int own_cyc, output int scl_rel);
    int prev, guard;
    own_cyc = 0; scl_rel = 0; guard = 0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    prev = int'(scl_oe);
    while (!done && guard < 5000) begin
      if (own) own_cyc++;
      if (prev == 1 && !scl_oe) scl_rel++;
      prev = int'(scl_oe);
      if (poke) go = (guard % 7 == 3);
      guard++;
      @(negedge clk);
    end
    go = 1'b0;
  endtask

  initial begin
    int oc, sr, s0, s1;
    rst_n = 0; go = 0; tick = 1; scl_hold = 0; sda_hold = 0;
    repeat (3) @(negedge clk);
    chk("R1 own", int'(own), 0);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ctrl_rst", int'(crst), 0);
    chk("R1 idle_ok", int'(ok), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_one(0, oc, sr);
    chk("R3 own length", oc, NSTEP * D);
    chk("R5 scl releases", sr, NP + 1);
    @(negedge clk);
    chk("R8 idle_ok high", int'(ok), 1);

    scl_hold = 1; tick_mode = 1;
    run_one(0, oc, sr);
    @(negedge clk);
    chk("R8 idle_ok low", int'(ok), 0);
    scl_hold = 0; tick_mode = 0;
    repeat (3) @(negedge clk);

    run_one(1, oc, sr);
    chk("R9 length with go noise", oc, NSTEP * D);
    chk("R9 scl releases", sr, NP + 1);

    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (10) @(negedge clk);
    tick_mode = 2;
    s0 = {int'(scl_oe), int'(sda_oe)};
    repeat (20) @(negedge clk);
    s1 = {int'(scl_oe), int'(sda_oe)};
    chk("R3 stall keeps lines", s1, s0);
    chk("R3 stall keeps own", int'(own), 1);
    tick_mode = 0;
    while (!done) @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    chk("R9 go ignored in done cycle", int'(own), 0);
    @(negedge clk);
    chk("R2 restart from idle", int'(own), 1);
    go = 1'b0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule